// File: doc/BRIEF.md
# Dual 8/16-bit Timer with Capture and Compare

This block holds two 8-bit count channels, and each one increments on a tick. The tick comes from a power-of-two prescaler or from rising edges on an external event pin. A channel has a match register. When the count equals the match value, the next tick returns the counter to zero and raises a one-cycle interrupt pulse. The period is therefore (match+1) ticks.

Each channel runs in one of three functions:
- In timer/counter function, the channel only counts.
- In capture function, the channel keeps counting, and a programmable edge on its capture pin copies the count into a read-only capture register.
- In compare function, the channel toggles an output pin on every match.

A chain bit joins the two channels into a single 16-bit counter. In that mode the first channel's controls drive both halves and its match register supplies the low byte.

Software programs the block through a simple byte-write port. Address 0 and address 1 are the control registers of channel 0 and channel 1. Addresses 2 and 3 are their match registers. Address 4 is the chain configuration.

Top module: `tmr_dual`

## Requirements
- R1: Control bit 0 enables a channel. Bits [4:1] select the clock, and a selector value s from 0 to 10 gives one tick every 2^(s+1) clock cycles on either channel. The irq spacing is then (match+1)·2^(s+1) cycles.
- R2: Selector values 11 to 14 give channel 1 one tick every 2^(s-11) cycles, which is a divide by 1, 2, 4 or 8. On channel 0 these values produce no ticks.
- R3: Selector value 15 counts the 0-to-1 transitions of ev_i of the channel, after a two-stage synchroniser.
- R4: On a tick where the count equals the match value, the counter becomes zero and irq_o of the channel is high for that one cycle. The match registers reset to 0xFF.
- R5: With bit 0 of register 4 set, the counter is a 16-bit value. Its clock, enable and function come from channel 0, and it is compared against {match1, match0}. irq_o[0] signals the match and irq_o[1] stays low.
- R6: While a channel is disabled, its counter and prescaler are held at zero. Any write to a control register or to register 4 also clears the affected counters and prescalers.
- R7: Control bits [6:5] = 2 select compare function, in which cmp_o of the channel inverts on every match. In other functions cmp_o holds its value.
- R8: Control bits [6:5] = 1 select capture function. Here the counter keeps counting, and the synchronised capin_i edge copies cnt into cap_o. Bit 7 picks the edge: 0 for rising, 1 for falling.
- R9: In functions other than capture, capin_i edges leave cap_o unchanged. In 16-bit capture both bytes are taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0..4) |
| wr_data_i | input | 8 | Write data |
| ev_i | input | 2 | External event inputs, one per channel |
| capin_i | input | 2 | Capture trigger inputs, one per channel |
| cnt_o | output | 16 | {channel 1 count, channel 0 count} |
| cap_o | output | 16 | {channel 1 capture, channel 0 capture} |
| irq_o | output | 2 | Match interrupt pulses |
| cmp_o | output | 2 | Toggling compare outputs |

## Verification
The bench builds the block with the default parameters: an 11-bit prescaler and two synchroniser stages. This setting makes every divisor reachable, including divide-by-2048 and the 249/divide-by-128 interval of 32000 cycles.

The bench sweeps the selector against several match values and checks each measured irq spacing against the formula. Event counts of 300 cross the byte boundary, so they exercise the carry between the chained halves and the same-cycle 16-bit capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL0  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MATCH0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MATCH1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd4;

  typedef enum logic [1:0] {
    FN_TIMER   = 2'd0,
    FN_CAPTURE = 2'd1,
    FN_COMPARE = 2'd2,
    FN_RSVD    = 2'd3
  } fn_e;

  typedef struct packed {
    logic       cap_fall;
    fn_e        fn;
    logic [3:0] clk_sel;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 11,
  parameter bit FAST  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [3:0] sel_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic [3:0]       k;
  logic             div_ok, ext_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    k       = '0;
    div_ok  = 1'b0;
    ext_sel = 1'b0;
    if (sel_i <= 4'd10) begin
      k      = sel_i + 4'd1;
      div_ok = 1'b1;
    end else if (sel_i == 4'd15) begin
      ext_sel = 1'b1;
    end else if (FAST) begin
      k      = sel_i - 4'd11;
      div_ok = 1'b1;
    end
    mask = ~({PRE_W{1'b1}} << k);
  end

  assign tick_o = ext_sel ? ext_tick_i : (div_ok && ((pre_q & mask) == mask));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q, cur;

  assign cur = sh_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= cur;
    end
  end

  assign edge_o = fall_sel_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual import tmr_pkg::*; #(
  parameter int PRE_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic [NCH-1:0]        ev_i,
  input  logic [NCH-1:0]        capin_i,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic [2*BYTE_W-1:0]   cap_o,
  output logic [NCH-1:0]        irq_o,
  output logic [NCH-1:0]        cmp_o
);
  localparam int W16 = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ONE8  = 1;
  localparam logic [W16-1:0]    ONE16 = 1;

  ctrl_t             ctrl_q [NCH];
  ctrl_t             ectl   [NCH];
  logic [BYTE_W-1:0] match_q[NCH];
  logic [BYTE_W-1:0] cnt_q  [NCH];
  logic [BYTE_W-1:0] cnt_d  [NCH];
  logic [BYTE_W-1:0] cap_q  [NCH];
  logic              chain_q, cfg_wr;
  logic [NCH-1:0]    ctrl_wr, hold, tick, ev_rise, cap_ev, irq_d, irq_q, cmp_q;
  logic [W16-1:0]    full_q, match_full;

  assign cfg_wr = wr_en_i && (wr_addr_i == ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_q[i]  <= '0;
        match_q[i] <= '1;
      end
      chain_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTRL0:  ctrl_q[0]  <= ctrl_t'(wr_data_i);
        ADDR_CTRL1:  ctrl_q[1]  <= ctrl_t'(wr_data_i);
        ADDR_MATCH0: match_q[0] <= wr_data_i;
        ADDR_MATCH1: match_q[1] <= wr_data_i;
        ADDR_CFG:    chain_q    <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ctrl_wr[i] = wr_en_i && (wr_addr_i == ADDR_CTRL0 + ADDR_W'(i));
    // in 16-bit mode the upper half follows channel 0
    assign ectl[i] = (chain_q && (i != 0)) ? ctrl_q[0] : ctrl_q[i];
    assign hold[i] = !ectl[i].en || cfg_wr || ctrl_wr[i] || (chain_q && (|ctrl_wr));

    tmr_prescaler #(.PRE_W(PRE_W), .FAST(i == 1)) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hold[i]),
      .sel_i(ectl[i].clk_sel), .ext_tick_i(ev_rise[i]), .tick_o(tick[i])
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ev (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ev_i[i]),
      .fall_sel_i(1'b0), .edge_o(ev_rise[i])
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(capin_i[i]),
      .fall_sel_i(ectl[i].cap_fall), .edge_o(cap_ev[i])
    );
  end

  assign full_q     = {cnt_q[1], cnt_q[0]};
  assign match_full = {match_q[1], match_q[0]};

  always_comb begin
    for (int i = 0; i < NCH; i++) cnt_d[i] = cnt_q[i];
    irq_d = '0;
    if (chain_q) begin
      if (tick[0]) begin
        if (full_q == match_full) begin
          cnt_d[0] = '0;
          cnt_d[1] = '0;
          irq_d[0] = 1'b1;
        end else begin
          {cnt_d[1], cnt_d[0]} = full_q + ONE16;
        end
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (tick[i]) begin
          if (cnt_q[i] == match_q[i]) begin
            cnt_d[i] = '0;
            irq_d[i] = 1'b1;
          end else begin
            cnt_d[i] = cnt_q[i] + ONE8;
          end
        end
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (hold[i]) begin
        cnt_d[i] = '0;
        irq_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        cnt_q[i] <= '0;
        cap_q[i] <= '0;
      end
      irq_q <= '0;
      cmp_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        cnt_q[i] <= cnt_d[i];
        if (irq_d[i] && (ectl[i].fn == FN_COMPARE)) cmp_q[i] <= ~cmp_q[i];
      end
      irq_q <= irq_d;
      if (chain_q) begin
        if (cap_ev[0] && (ectl[0].fn == FN_CAPTURE)) begin
          cap_q[0] <= cnt_q[0];
          cap_q[1] <= cnt_q[1];
        end
      end else begin
        for (int i = 0; i < NCH; i++)
          if (cap_ev[i] && (ectl[i].fn == FN_CAPTURE)) cap_q[i] <= cnt_q[i];
      end
    end
  end

  assign cnt_o = full_q;
  assign cap_o = {cap_q[1], cap_q[0]};
  assign irq_o = irq_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en0_i,
  input logic [1:0]  fn0_i,
  input logic        chain_i,
  input logic [15:0] cnt_i,
  input logic [7:0]  cap_lo_i,
  input logic [1:0]  irq_i,
  input logic        cmp0_i
);
  p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] |-> (cnt_i[7:0] == 8'd0));

  p_wrap_zero_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[1] |-> (cnt_i[15:8] == 8'd0));

  p_chain_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_i |=> !irq_i[1]);

  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en0_i |=> (cnt_i[7:0] == 8'd0));

  p_cmp_on_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp0_i) |-> irq_i[0]);

  p_cap_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn0_i != 2'd1) |=> $stable(cap_lo_i));
endmodule

bind tmr_dual tmr_dual_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en0_i   (ctrl_q[0].en),
  .fn0_i   (ctrl_q[0].fn),
  .chain_i (chain_q),
  .cnt_i   (cnt_o),
  .cap_lo_i(cap_o[7:0]),
  .irq_i   (irq_o),
  .cmp0_i  (cmp_o[0])
);

// File: tb/tmr_dual_tb_top.sv
module tmr_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  ev = '0;
  logic [1:0]  capin = '0;
  logic [15:0] cnt_o, cap_o;
  logic [1:0]  irq_o, cmp_o;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tmr_dual dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ev_i(ev), .capin_i(capin),
    .cnt_o(cnt_o), .cap_o(cap_o), .irq_o(irq_o), .cmp_o(cmp_o)
  );

  function automatic logic [7:0] ctl(input bit en, input int sel, input int fn, input bit fall);
    return {fall, 2'(fn), 4'(sel), en};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic period(input int ch, output int p);
    int g = 0;
    do begin @(negedge clk); g++; end while (!irq_o[ch] && g < 40000);
    p = 0;
    do begin @(negedge clk); p++; end while (!irq_o[ch] && p < 40000);
  endtask

  task automatic pulses(input int ch, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) ev[ch] = 1'b1;
      @(negedge clk);
      @(negedge clk) ev[ch] = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cap(input int ch, input logic v);
    @(negedge clk) capin[ch] = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int p, ni, nt;
    int mv[3] = '{0, 1, 5};
    logic pc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R4 reset cnt", int'(cnt_o), 0);
    check("R4 reset cap", int'(cap_o), 0);
    check("R4 reset irq/cmp", int'({irq_o, cmp_o}), 0);

    // R1: slow divisors on channel 0
    for (int s = 0; s < 5; s++)
      for (int mi = 0; mi < 3; mi++) begin
        wr(3'd2, 8'(mv[mi]));
        wr(3'd0, ctl(1, s, 0, 0));
        period(0, p);
        check("R1 ch0 period", p, (mv[mi] + 1) << (s + 1));
      end
    wr(3'd2, 8'd0); wr(3'd0, ctl(1, 10, 0, 0));
    period(0, p);
    check("R1 ch0 div2048", p, 2048);
    wr(3'd2, 8'd249); wr(3'd0, ctl(1, 6, 0, 0));
    period(0, p);
    check("R1 ch0 249 div128", p, 32000);
    for (int s = 0; s < 3; s++) begin
      wr(3'd3, 8'd3); wr(3'd1, ctl(1, s, 0, 0));
      period(1, p);
      check("R1 ch1 period", p, 4 << (s + 1));
    end

    // R2: fast divisors on channel 1, none on channel 0
    for (int s = 11; s < 15; s++)
      for (int mi = 0; mi < 3; mi++) begin
        wr(3'd3, 8'(mv[mi] + mi));
        wr(3'd1, ctl(1, s, 0, 0));
        period(1, p);
        check("R2 ch1 fast period", p, (mv[mi] + mi + 1) << (s - 11));
      end
    wr(3'd2, 8'd0); wr(3'd0, ctl(1, 12, 0, 0));
    ni = 0;
    for (int j = 0; j < 60; j++) begin @(negedge clk); if (irq_o[0]) ni++; end
    check("R2 ch0 reserved sel cnt", int'(cnt_o[7:0]), 0);
    check("R2 ch0 reserved sel irq", ni, 0);

    // R3: event counting with wrap on channel 1
    wr(3'd1, 8'd0);
    wr(3'd3, 8'd4); wr(3'd1, ctl(1, 15, 0, 0));
    pulses(1, 7);
    check("R3 ch1 events mod 5", int'(cnt_o[15:8]), 2);

    // R6: disable and control writes clear
    wr(3'd2, 8'hFF); wr(3'd0, ctl(1, 15, 0, 0));
    pulses(0, 5);
    check("R3 ch0 events", int'(cnt_o[7:0]), 5);
    wr(3'd0, ctl(1, 15, 0, 0));
    check("R6 ctrl write clears", int'(cnt_o[7:0]), 0);
    pulses(0, 3);
    check("R6 count after rewrite", int'(cnt_o[7:0]), 3);
    wr(3'd0, ctl(0, 15, 0, 0));
    check("R6 disable clears", int'(cnt_o[7:0]), 0);
    pulses(0, 3);
    check("R6 disabled ignores events", int'(cnt_o[7:0]), 0);

    // R7: compare toggling
    wr(3'd2, 8'd1); wr(3'd0, ctl(1, 0, 2, 0));
    ni = 0; nt = 0; pc = cmp_o[0];
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (irq_o[0]) ni++;
      if (cmp_o[0] != pc) nt++;
      pc = cmp_o[0];
    end
    check("R7 toggles equal matches", nt, ni);
    check("R7 matches seen", int'(ni >= 49), 1);
    wr(3'd0, ctl(1, 0, 0, 0));
    nt = 0; pc = cmp_o[0];
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      if (cmp_o[0] != pc) nt++;
      pc = cmp_o[0];
    end
    check("R7 timer fn holds cmp", nt, 0);

    // R8: capture on channel 1, rising then falling
    wr(3'd3, 8'd3); wr(3'd1, ctl(1, 15, 1, 0));
    pulses(1, 6);
    set_cap(1, 1'b1);
    check("R8 rising capture", int'(cap_o[15:8]), 2);
    pulses(1, 1);
    check("R8 keeps counting", int'(cnt_o[15:8]), 3);
    wr(3'd1, ctl(1, 15, 1, 1));
    pulses(1, 3);
    set_cap(1, 1'b0);
    check("R8 falling capture", int'(cap_o[15:8]), 3);
    set_cap(1, 1'b1);
    check("R8 rising ignored when falling", int'(cap_o[15:8]), 3);
    pulses(1, 1);
    set_cap(1, 1'b0);
    check("R8 falling after wrap", int'(cap_o[15:8]), 0);

    // R5: 16-bit timer and event count
    wr(3'd4, 8'd1);
    wr(3'd2, 8'd3); wr(3'd3, 8'd1); wr(3'd0, ctl(1, 0, 0, 0));
    period(0, p);
    check("R5 16-bit period", p, 520);
    ni = 0;
    for (int j = 0; j < 600; j++) begin @(negedge clk); if (irq_o[1]) ni++; end
    check("R5 irq1 quiet", ni, 0);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, ctl(1, 15, 0, 0));
    pulses(0, 300);
    check("R5 16-bit event carry", int'(cnt_o), 300);

    // R9: 16-bit capture takes both bytes
    set_cap(0, 1'b0);
    wr(3'd0, ctl(1, 15, 1, 0));
    pulses(0, 300);
    set_cap(0, 1'b1);
    check("R9 16-bit capture", int'(cap_o), 300);
    pulses(0, 2);
    check("R8 16-bit keeps counting", int'(cnt_o), 302);

    // R9: capture ignored in timer function
    wr(3'd4, 8'd0);
    wr(3'd0, ctl(1, 15, 0, 0));
    set_cap(0, 1'b0);
    pulses(0, 4);
    set_cap(0, 1'b1);
    check("R9 ignored in timer fn", int'(cap_o[7:0]), 44);
    check("R9 count unaffected", int'(cnt_o[7:0]), 4);

    finish_run();
  end
endmodule